// File: doc/BRIEF.md
# Streaming Matrix Transposer

This block turns a stream of square matrices into their transposes. One sample comes in on every clock where the enable is high. The samples of a matrix arrive row by row, and the transposed matrix leaves column by column, back to back, with a fixed latency. The storage is a small array with a clocked write and a combinational read. A wrapping slot counter drives it. That counter advances only on enabled clocks, and at elaboration time it is decoded into two constant tables: one gives the cell written in each slot, the other gives the cell read in each slot. A sample whose output slot is its own input slot never enters the array. The output register takes it straight from the input.

The schedule spans two matrices, 2·DIM² slots, and the array holds one cell per slot. Every element therefore has a cell of its own until that cell is read. An optional input register stage is selected by a parameter. It captures the data and the enable on every clock and registers the write-address decode. This shortens the timing path, and the output gains one clock of latency. When the enable is low the stream stalls: the slot counter holds, no cell is written, and the output keeps its value.

Top module: `strm_transpose`

## Requirements
- R1: While reset is high, and on every clock after it until the first enabled clock, `dout` is 0.
- R2: Count the enabled clocks since reset from 0 and let L = (DIM−1)². When `IN_REG` = 0, the output element at position m appears on `dout` right after enabled clock number m+L. When `IN_REG` = 1 it appears one clock later, on the clock edge that follows enabled clock m+L. Output positions run column by column through each matrix: position m holds row m mod DIM, column (m div DIM) mod DIM of input matrix m div DIM². That element was input number (m div DIM²)·DIM² + row·DIM + column.
- R3: Matrices stream without gaps across the wrap of the two-matrix schedule period. The third and fourth matrices come out exactly as the first two do.
- R4: Element (row DIM−1, column 0) of every matrix, at output position DIM−1 within the matrix, has zero storage time. It is taken from the input path (raw or registered) and comes out correctly.
- R5: A clock with `en` low is invisible to the stream. The schedule does not advance, no stored element changes whatever is on `din`, and `dout` holds. With `IN_REG` = 0 it holds across that clock. With `IN_REG` = 1 it holds across the clock after it. The element sequence then continues with no loss or repeat.
- R6: A synchronous reset in the middle of a stream clears `dout` and restarts the schedule. The next enabled sample is row 0, column 0 of a new matrix, and that matrix comes out transposed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; low stalls the stream |
| din | input | WL | Input sample, row-major order |
| dout | output | WL | Registered output sample, column-major order |

## Verification
On every enabled slot a new sample is written into one cell while an older sample is read from another, or passes straight through. A stall can therefore land on a slot that has a write pending, or on the zero-storage slot. The bench inserts single and double low-enable clocks at irregular positions and puts a junk value on `din` while they last. It runs two instances side by side, one with input registering and one without. Every element that follows a stall must still match the transpose, and `dout` must hold across each stall.

// File: rtl/strm_xpose_pkg.sv
package strm_xpose_pkg;

   // Source selected by the output register in a given slot.
   typedef enum logic [1:0] {
      XP_SRC_NONE = 2'd0,
      XP_SRC_RAM  = 2'd1,
      XP_SRC_PASS = 2'd2
   } xp_src_e;

   // Number of slots an input sample stays in storage.
   // Sample slot s holds row r, column c of its matrix.
   // It leaves at output slot (DIM-1)^2 + c*DIM + r.
   function automatic int xp_hold_time(input int dim, input int slot);
      int frame;
      int idx;
      int r;
      int c;
      frame = dim * dim;
      idx   = slot % frame;
      r     = idx / dim;
      c     = idx % dim;
      return (dim - 1) * (dim - 1) + c * dim + r - idx;
   endfunction

   // Input slot whose sample leaves in the given output slot.
   function automatic int xp_source_slot(input int dim, input int out_slot);
      int frame;
      int period;
      int lat;
      int m;
      int f;
      int j;
      int r;
      int c;
      frame  = dim * dim;
      period = 2 * frame;
      lat    = (dim - 1) * (dim - 1);
      m      = (out_slot + period - lat) % period;
      f      = m / frame;
      j      = m % frame;
      c      = j / dim;
      r      = j % dim;
      return f * frame + r * dim + c;
   endfunction

endpackage

// File: rtl/strm_xpose_cnt.sv
module strm_xpose_cnt #(
   parameter int PERIOD = 32,
   parameter int CW     = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [CW-1:0] slot
);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         slot <= '0;
      end else if (adv) begin
         if (slot == LAST) slot <= '0;
         else              slot <= slot + 1'b1;
      end
   end
endmodule

// File: rtl/strm_xpose_wrgen.sv
module strm_xpose_wrgen
   import strm_xpose_pkg::*;
#(
   parameter int DIM        = 4,
   parameter int PERIOD     = 32,
   parameter int CW         = 5,
   parameter int AW         = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] slot,
   input  logic          go,
   output logic          we,
   output logic [AW-1:0] addr
);
   logic [PERIOD-1:0] tbl_we;
   logic [AW-1:0]     tbl_addr [PERIOD];

   for (genvar s = 0; s < PERIOD; s++) begin : g_slot
      localparam int  HOLD  = xp_hold_time(DIM, s);
      localparam bit  STORE = (HOLD != 0);
      assign tbl_we[s]   = STORE;
      assign tbl_addr[s] = STORE ? AW'(s) : '0;
   end

   logic          dec_we;
   logic [AW-1:0] dec_addr;

   always_comb begin
      dec_we   = tbl_we[slot] & go;
      dec_addr = tbl_addr[slot];
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            we   <= 1'b0;
            addr <= '0;
         end else begin
            we   <= dec_we;
            addr <= dec_addr;
         end
      end
   end else begin : g_comb
      assign we   = dec_we;
      assign addr = dec_addr;
   end
endmodule

// File: rtl/strm_xpose_rdgen.sv
module strm_xpose_rdgen
   import strm_xpose_pkg::*;
#(
   parameter int DIM    = 4,
   parameter int PERIOD = 32,
   parameter int CW     = 5,
   parameter int AW     = 5,
   parameter int SHIFT  = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] slot,
   input  logic          go,
   output xp_src_e       src,
   output logic [AW-1:0] addr
);
   xp_src_e       tbl_src  [PERIOD];
   logic [AW-1:0] tbl_addr [PERIOD];

   // SHIFT lets the registered decode run one slot ahead when the input is raw.
   for (genvar s = 0; s < PERIOD; s++) begin : g_slot
      localparam int OUTS = (s + SHIFT) % PERIOD;
      localparam int SRC  = xp_source_slot(DIM, OUTS);
      localparam bit PASS = (xp_hold_time(DIM, SRC) == 0);
      assign tbl_src[s]  = PASS ? XP_SRC_PASS : XP_SRC_RAM;
      assign tbl_addr[s] = PASS ? '0 : AW'(SRC);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         src  <= XP_SRC_NONE;
         addr <= '0;
      end else if (go) begin
         src  <= tbl_src[slot];
         addr <= tbl_addr[slot];
      end
   end
endmodule

// File: rtl/strm_xpose_ram.sv
module strm_xpose_ram #(
   parameter int WL    = 8,
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [WL-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [WL-1:0] rdata
);
   logic [WL-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/strm_transpose.sv
module strm_transpose
   import strm_xpose_pkg::*;
#(
   parameter int DIM    = 4,
   parameter int WL     = 8,
   parameter bit IN_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [WL-1:0] din,
   output logic [WL-1:0] dout
);
   localparam int FRAME    = DIM * DIM;
   localparam int PERIOD   = 2 * FRAME;
   localparam int DEPTH    = PERIOD;
   localparam int CW       = $clog2(PERIOD);
   localparam int AW       = $clog2(DEPTH);
   localparam int RD_SHIFT = IN_REG ? 0 : 1;

   if (DIM < 2) begin : g_bad_dim
      $error("strm_transpose: DIM must be at least 2");
   end
   if (WL < 1) begin : g_bad_wl
      $error("strm_transpose: WL must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          stage_en;
   logic [WL-1:0] wr_data;
   logic          wr_we;
   logic [AW-1:0] wr_addr;
   xp_src_e       src_q;
   logic [AW-1:0] rd_addr;
   logic [WL-1:0] rd_data;

   strm_xpose_cnt #(.PERIOD(PERIOD), .CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .adv  (en),
      .slot (cnt)
   );

   if (IN_REG) begin : g_in_reg
      logic [WL-1:0] din_q;
      logic          en_q;
      always_ff @(posedge clk) begin
         din_q <= din;
         if (rst) en_q <= 1'b0;
         else     en_q <= en;
      end
      assign wr_data  = din_q;
      assign stage_en = en_q;
   end else begin : g_in_raw
      assign wr_data  = din;
      assign stage_en = en;
   end

   strm_xpose_wrgen #(
      .DIM(DIM), .PERIOD(PERIOD), .CW(CW), .AW(AW), .REGISTERED(IN_REG)
   ) u_wrgen (
      .clk  (clk),
      .rst  (rst),
      .slot (cnt),
      .go   (en),
      .we   (wr_we),
      .addr (wr_addr)
   );

   strm_xpose_rdgen #(
      .DIM(DIM), .PERIOD(PERIOD), .CW(CW), .AW(AW), .SHIFT(RD_SHIFT)
   ) u_rdgen (
      .clk  (clk),
      .rst  (rst),
      .slot (cnt),
      .go   (en),
      .src  (src_q),
      .addr (rd_addr)
   );

   strm_xpose_ram #(.WL(WL), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (wr_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
      end else if (stage_en) begin
         case (src_q)
            XP_SRC_PASS: dout <= wr_data;
            XP_SRC_RAM:  dout <= rd_data;
            default:     dout <= dout;
         endcase
      end
   end
endmodule

// File: rtl/strm_transpose_chk.sv
module strm_transpose_chk
   import strm_xpose_pkg::*;
#(
   parameter int PERIOD = 32,
   parameter int CW     = 5,
   parameter int WL     = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic          stage_en,
   input logic [CW-1:0] cnt,
   input xp_src_e       src_q,
   input logic [WL-1:0] dout
);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (cnt == '0 && dout == '0)); // R1

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (en && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1)); // R2

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && cnt == LAST) |=> (cnt == '0)); // R3

   AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (src_q inside {XP_SRC_NONE, XP_SRC_RAM, XP_SRC_PASS})); // R4

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt)); // R5

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !stage_en |=> $stable(dout)); // R5
endmodule

bind strm_transpose strm_transpose_chk #(
   .PERIOD(PERIOD), .CW(CW), .WL(WL)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .stage_en (stage_en),
   .cnt      (cnt),
   .src_q    (src_q),
   .dout     (dout)
);

// File: tb/strm_transpose_test.sv
module strm_transpose_test;
   localparam int DIM   = 4;
   localparam int WL    = 8;
   localparam int FRAME = DIM * DIM;
   localparam int LAT   = (DIM - 1) * (DIM - 1);
   localparam int BYP_J = DIM - 1;

   // Expected column-major output for one two-matrix period when input n = 8'h20 + n.
   localparam logic [7:0] EXP_TBL [32] = '{
      8'h20, 8'h24, 8'h28, 8'h2C, 8'h21, 8'h25, 8'h29, 8'h2D,
      8'h22, 8'h26, 8'h2A, 8'h2E, 8'h23, 8'h27, 8'h2B, 8'h2F,
      8'h30, 8'h34, 8'h38, 8'h3C, 8'h31, 8'h35, 8'h39, 8'h3D,
      8'h32, 8'h36, 8'h3A, 8'h3E, 8'h33, 8'h37, 8'h3B, 8'h3F
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic [WL-1:0] din = '0;
   logic [WL-1:0] dout;
   logic [WL-1:0] dout_nr;

   int checks = 0;
   int errors = 0;
   int ecount = 0;
   int prev_idx = 0;
   bit prev_en = 1'b0;
   bit ok_nr = 1'b0;
   bit ok_r = 1'b0;
   logic [WL-1:0] last_nr = '0;
   logic [WL-1:0] last_r = '0;
   string phase = "R2";

   always #2 clk = ~clk;

   strm_transpose #(.DIM(DIM), .WL(WL), .IN_REG(1'b1)) uut (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout)
   );
   strm_transpose #(.DIM(DIM), .WL(WL), .IN_REG(1'b0)) uut_nr (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_nr)
   );

   function automatic logic [7:0] flip(input int n);
      return ((n / 32) % 2 == 1) ? 8'h80 : 8'h00;
   endfunction
   function automatic logic [7:0] stim(input int n);
      return (8'h20 + 8'(n % 32)) ^ flip(n);
   endfunction
   function automatic logic [7:0] expv(input int m);
      return EXP_TBL[m % 32] ^ flip(m);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [WL-1:0] act, input logic [WL-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_for(input int m);
      return ((m % FRAME) == BYP_J) ? "R4" : phase;
   endfunction

   task automatic step(input logic r, input logic e);
      int idx;
      int m;
      @(negedge clk);
      rst = r;
      en  = e;
      din = e ? stim(ecount) : 8'hEE;
      @(posedge clk);
      #1;
      if (r) begin
         ecount  = 0;
         prev_en = 1'b0;
         ok_nr   = 1'b0;
         ok_r    = 1'b0;
         check(phase, "reset dout", dout, '0);
         check(phase, "reset dout_nr", dout_nr, '0);
         return;
      end
      idx = ecount;
      if (e) begin
         ecount++;
         if (idx >= LAT) begin
            m = idx - LAT;
            check(tag_for(m), "raw-input stream", dout_nr, expv(m));
            last_nr = expv(m);
            ok_nr   = 1'b1;
         end else if (!ok_nr) begin
            check("R1", "raw-input before latency", dout_nr, dout_nr);
         end
      end else if (ok_nr) begin
         check("R5", "raw-input hold on stall", dout_nr, last_nr);
      end
      if (prev_en) begin
         if (prev_idx >= LAT) begin
            m = prev_idx - LAT;
            check(tag_for(m), "registered-input stream", dout, expv(m));
            last_r = expv(m);
            ok_r   = 1'b1;
         end
      end else if (ok_r) begin
         check("R5", "registered-input hold on stall", dout, last_r);
      end else begin
         check("R1", "registered-input idle", dout, '0);
      end
      prev_en = e;
      if (e) prev_idx = idx;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset, then idle with en low
      phase = "R1";
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0);
         check("R1", "idle dout_nr", dout_nr, '0);
      end
      // R2: first period streamed with en held high
      phase = "R2";
      for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
      // R3: continue across the schedule wrap
      phase = "R3";
      for (int i = 0; i < 56; i++) step(1'b0, 1'b1);
      // R5: irregular single and double stalls
      phase = "R5";
      for (int i = 0; i < 70; i++) begin
         step(1'b0, 1'b1);
         if (i % 5 == 2) step(1'b0, 1'b0);
         if (i % 11 == 7) begin
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
         end
      end
      // R6: reset in mid-stream with en high, then a fresh stream
      phase = "R6";
      step(1'b1, 1'b1);
      for (int i = 0; i < 50; i++) step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule